// File: doc/BRIEF.md
# Pipeline Interlock and Operand Bypass Controller

This block decides, once per clock, whether the decode stage of a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back) may advance. It receives only the decoded register numbers of the instruction in decode, together with its valid and "source used" flags. It also receives the destination number and the valid, writes-register and is-load flags of the instructions in execute and memory. From these it drives the hold signals for the program counter and the fetch/decode register, a bubble request for the decode/execute register, and a discard signal for the fetched slot behind a taken branch.

A static mode input chooses between two schemes. With bypassing off, a consumer waits in decode until its producer has reached write-back; the register file is written and read in the same cycle. With bypassing on, results are steered to the execute inputs. Only a load followed at once by a user of its result still waits one cycle. The operand selects are registered, so they are valid for the instruction that is in execute in the following cycle.

Two free-running counters record retired instructions and inserted empty slots. A test environment can use them to work out cycles per instruction as (retired + empty slots + 4) / retired.

Top module: `hz_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both operand selects read 00 and both counters read zero.
- R2: With bypassing off, a used, non-zero source of a valid decode instruction that equals the destination of a valid, register-writing instruction in execute or in memory raises stall_pc, stall_ifid and bubble_idex in that same cycle.
- R3: With bypassing on, a match against a non-load writer in execute causes no stall, and in the next cycle that operand's select reads 10 (execute/memory ALU result). A match against a writer in memory causes no stall, and the next-cycle select reads 01 (memory/write-back result).
- R4: When a source matches writers in both execute and memory, the execute one wins: the next-cycle select reads 10.
- R5: With bypassing on, a load in execute whose destination matches a used source stalls for that cycle. When the load is in memory in the next cycle, the same consumer proceeds without a stall and its select then reads 01.
- R6: Register 0, a source whose used flag is low, and a producer whose writes-register flag or valid flag is low never cause a stall and never give a select other than 00.
- R7: The second source field (store data or branch condition) is checked exactly like the first and drives its own select, fwd_b_sel.
- R8: When br_taken is high, flush_ifid is high and stall_pc, stall_ifid and bubble_idex are low in that cycle, even if a data hazard is present.
- R9: In the cycle after a bubble is inserted, or whenever bypassing is off, both selects read 00.
- R10: retired_cnt rises by one for each cycle with wb_valid high. bubble_cnt rises by one for each cycle in which bubble_idex or flush_ifid is high. Both values appear one cycle later.
- R11: A decode slot with id_valid low never causes a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fwd_en | input | 1 | Bypass mode: 1 = bypassing on |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_rs1 | input | 5 | First source register number |
| id_rs1_used | input | 1 | First source is read |
| id_rs2 | input | 5 | Second source register number |
| id_rs2_used | input | 1 | Second source is read |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_rd | input | 5 | Execute-stage destination |
| ex_wr | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| mem_valid | input | 1 | Memory stage holds a real instruction |
| mem_rd | input | 5 | Memory-stage destination |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| wb_valid | input | 1 | An instruction retires this cycle |
| br_taken | input | 1 | Control transfer taken; discard the fetched slot |
| stall_pc | output | 1 | Hold the program counter |
| stall_ifid | output | 1 | Hold the fetch/decode register |
| bubble_idex | output | 1 | Load an empty slot into decode/execute |
| flush_ifid | output | 1 | Replace the fetched slot with an empty slot |
| fwd_a_sel | output | 2 | First operand select: 00 file, 01 mem/wb, 10 ex/mem |
| fwd_b_sel | output | 2 | Second operand select, same encoding |
| retired_cnt | output | 16 | Retired instruction count |
| bubble_cnt | output | 16 | Inserted empty slot count |

## Verification
The hold, bubble and discard outputs are combinational, so they are due in the same cycle as the stage fields that cause them. The bench drives each pattern just after a falling edge and samples these outputs a couple of nanoseconds later, before the next rising edge. The operand selects and both counters pass through one register each, so they are due one cycle after the stimulus. Each scenario task samples them at the next falling edge, after the capturing rising edge. For the load case the task first checks the stall cycle and then moves the load into memory to check the follow-up cycle.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef logic [1:0] fwd_sel_t;

    localparam fwd_sel_t FWD_RF  = 2'b00;
    localparam fwd_sel_t FWD_WB  = 2'b01;
    localparam fwd_sel_t FWD_EXM = 2'b10;

    localparam int NUM_SRC = 2;

endpackage

// File: rtl/hz_src_check.sv
module hz_src_check
    import hz_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          fwd_en,
    input  logic          id_valid,
    input  logic          used,
    input  logic [AW-1:0] src,
    input  logic          ex_valid,
    input  logic          ex_wr,
    input  logic          ex_load,
    input  logic [AW-1:0] ex_rd,
    input  logic          mem_valid,
    input  logic          mem_wr,
    input  logic [AW-1:0] mem_rd,
    output logic          need_stall,
    output fwd_sel_t      sel_next
);

    logic live;
    logic hit_ex;
    logic hit_mem;

    always_comb begin
        live    = id_valid && used && (src != '0);
        hit_ex  = live && ex_valid && ex_wr && (ex_rd == src);
        hit_mem = live && mem_valid && mem_wr && (mem_rd == src);

        need_stall = 1'b0;
        sel_next   = FWD_RF;
        if (!fwd_en) begin
            // result only visible once producer writes back
            need_stall = hit_ex || hit_mem;
        end else if (hit_ex) begin
            // youngest producer wins; a load's data is not ready yet
            if (ex_load) begin
                need_stall = 1'b1;
            end else begin
                sel_next = FWD_EXM;
            end
        end else if (hit_mem) begin
            sel_next = FWD_WB;
        end
    end

    // R6, R11: an operand that reads nothing live never interlocks or bypasses
    always_comb begin
        if (!live) begin
            a_r6_dead_source: assert (!need_stall && sel_next == FWD_RF);
        end
    end

endmodule

// File: rtl/hz_ctl.sv
module hz_ctl
    import hz_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_SRC-1:0]      src_stall,
    input  fwd_sel_t [NUM_SRC-1:0]  src_sel,
    input  logic                    br_taken,
    output logic                    stall_pc,
    output logic                    stall_ifid,
    output logic                    bubble_idex,
    output logic                    flush_ifid,
    output fwd_sel_t [NUM_SRC-1:0]  fwd_sel
);

    typedef struct packed {
        fwd_sel_t [NUM_SRC-1:0] sel;
    } ctl_state_t;

    ctl_state_t st_d;
    ctl_state_t st_q;
    logic       data_hold;

    always_comb begin
        data_hold   = (|src_stall) && !br_taken;
        stall_pc    = data_hold;
        stall_ifid  = data_hold;
        bubble_idex = data_hold;
        flush_ifid  = br_taken;

        st_d = st_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            st_d.sel[i] = data_hold ? FWD_RF : src_sel[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fwd_sel = st_q.sel;

    // R8: a taken transfer discards the fetched slot and never holds
    a_r8_flush_wins: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> (flush_ifid && !stall_pc && !bubble_idex));

    // R9: the slot that follows an inserted bubble reads only the file
    a_r9_bubble_no_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_idex |=> (fwd_sel[0] == FWD_RF && fwd_sel[1] == FWD_RF));

    // R2: every hold is accompanied by a bubble downstream
    a_r2_hold_with_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_pc || stall_ifid) |-> bubble_idex);

endmodule

// File: rtl/hz_perf.sv
module hz_perf #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retire,
    input  logic             empty_slot,
    output logic [CNT_W-1:0] retired_cnt,
    output logic [CNT_W-1:0] bubble_cnt
);

    typedef struct packed {
        logic [CNT_W-1:0] ret;
        logic [CNT_W-1:0] bub;
    } perf_t;

    perf_t pf_d;
    perf_t pf_q;

    always_comb begin
        pf_d = pf_q;
        if (retire) begin
            pf_d.ret = pf_q.ret + 1'b1;
        end
        if (empty_slot) begin
            pf_d.bub = pf_q.bub + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_q <= '0;
        end else begin
            pf_q <= pf_d;
        end
    end

    assign retired_cnt = pf_q.ret;
    assign bubble_cnt  = pf_q.bub;

    // R10: one step per retiring cycle, no movement otherwise
    a_r10_retire_step: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> (retired_cnt == $past(retired_cnt) + 1'b1));

    a_r10_retire_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !retire |=> $stable(retired_cnt));

endmodule

// File: rtl/hz_unit.sv
module hz_unit
    import hz_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int CNT_W    = 16,
    localparam int AW      = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fwd_en,
    input  logic             id_valid,
    input  logic [AW-1:0]    id_rs1,
    input  logic             id_rs1_used,
    input  logic [AW-1:0]    id_rs2,
    input  logic             id_rs2_used,
    input  logic             ex_valid,
    input  logic [AW-1:0]    ex_rd,
    input  logic             ex_wr,
    input  logic             ex_load,
    input  logic             mem_valid,
    input  logic [AW-1:0]    mem_rd,
    input  logic             mem_wr,
    input  logic             wb_valid,
    input  logic             br_taken,
    output logic             stall_pc,
    output logic             stall_ifid,
    output logic             bubble_idex,
    output logic             flush_ifid,
    output logic [1:0]       fwd_a_sel,
    output logic [1:0]       fwd_b_sel,
    output logic [CNT_W-1:0] retired_cnt,
    output logic [CNT_W-1:0] bubble_cnt
);

    logic [AW-1:0]          src_num  [NUM_SRC];
    logic                   src_used [NUM_SRC];
    logic [NUM_SRC-1:0]     src_stall;
    fwd_sel_t [NUM_SRC-1:0] src_sel;
    fwd_sel_t [NUM_SRC-1:0] fwd_sel;

    assign src_num[0]  = id_rs1;
    assign src_num[1]  = id_rs2;
    assign src_used[0] = id_rs1_used;
    assign src_used[1] = id_rs2_used;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        hz_src_check #(
            .AW (AW)
        ) u_chk (
            .fwd_en     (fwd_en),
            .id_valid   (id_valid),
            .used       (src_used[g]),
            .src        (src_num[g]),
            .ex_valid   (ex_valid),
            .ex_wr      (ex_wr),
            .ex_load    (ex_load),
            .ex_rd      (ex_rd),
            .mem_valid  (mem_valid),
            .mem_wr     (mem_wr),
            .mem_rd     (mem_rd),
            .need_stall (src_stall[g]),
            .sel_next   (src_sel[g])
        );
    end

    hz_ctl u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_stall   (src_stall),
        .src_sel     (src_sel),
        .br_taken    (br_taken),
        .stall_pc    (stall_pc),
        .stall_ifid  (stall_ifid),
        .bubble_idex (bubble_idex),
        .flush_ifid  (flush_ifid),
        .fwd_sel     (fwd_sel)
    );

    hz_perf #(
        .CNT_W (CNT_W)
    ) u_perf (
        .clk         (clk),
        .rst_n       (rst_n),
        .retire      (wb_valid),
        .empty_slot  (bubble_idex || flush_ifid),
        .retired_cnt (retired_cnt),
        .bubble_cnt  (bubble_cnt)
    );

    assign fwd_a_sel = fwd_sel[0];
    assign fwd_b_sel = fwd_sel[1];

    // R3: bypass mode never holds for a non-load producer in execute
    a_r3_alu_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_en && ex_valid && ex_wr && !ex_load && !mem_valid) |-> !stall_pc);

    // R11: an empty decode slot never holds the front end
    a_r11_empty_id: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid |-> !stall_pc);

endmodule

// File: tb/hz_unit_bench.sv
module hz_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fwd_en, id_valid, id_rs1_used, id_rs2_used;
    logic [4:0]  id_rs1, id_rs2, ex_rd, mem_rd;
    logic        ex_valid, ex_wr, ex_load, mem_valid, mem_wr, wb_valid, br_taken;
    logic        stall_pc, stall_ifid, bubble_idex, flush_ifid;
    logic [1:0]  fwd_a_sel, fwd_b_sel;
    logic [15:0] retired_cnt, bubble_cnt;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    hz_unit u_hz_unit (
        .clk(clk), .rst_n(rst_n), .fwd_en(fwd_en), .id_valid(id_valid),
        .id_rs1(id_rs1), .id_rs1_used(id_rs1_used),
        .id_rs2(id_rs2), .id_rs2_used(id_rs2_used),
        .ex_valid(ex_valid), .ex_rd(ex_rd), .ex_wr(ex_wr), .ex_load(ex_load),
        .mem_valid(mem_valid), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .wb_valid(wb_valid), .br_taken(br_taken),
        .stall_pc(stall_pc), .stall_ifid(stall_ifid), .bubble_idex(bubble_idex),
        .flush_ifid(flush_ifid), .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
        .retired_cnt(retired_cnt), .bubble_cnt(bubble_cnt)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle();
        id_valid = 0; id_rs1 = 0; id_rs1_used = 0; id_rs2 = 0; id_rs2_used = 0;
        ex_valid = 0; ex_rd = 0; ex_wr = 0; ex_load = 0;
        mem_valid = 0; mem_rd = 0; mem_wr = 0; wb_valid = 0; br_taken = 0;
    endtask

    task automatic consumer(input logic [4:0] a, input logic [4:0] b);
        id_valid = 1; id_rs1 = a; id_rs1_used = 1; id_rs2 = b; id_rs2_used = 1;
    endtask

    task automatic hold_bits(input string req, input int exp);
        chk({req, " stall_pc"}, stall_pc, exp);
        chk({req, " stall_ifid"}, stall_ifid, exp);
        chk({req, " bubble_idex"}, bubble_idex, exp);
    endtask

    task automatic do_reset();
        rst_n = 0; idle(); fwd_en = 0;
        repeat (2) @(negedge clk);
        // R1: state while reset is held
        chk("R1 sel_a", fwd_a_sel, 0);
        chk("R1 sel_b", fwd_b_sel, 0);
        chk("R1 retired", retired_cnt, 0);
        chk("R1 bubbles", bubble_cnt, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 bubbles after release", bubble_cnt, 0);
    endtask

    task automatic t_nofwd();
        fwd_en = 0;
        @(negedge clk); idle(); consumer(5'd7, 5'd0);
        ex_valid = 1; ex_wr = 1; ex_rd = 5'd7;
        #2 hold_bits("R2 ex match", 1);
        @(negedge clk);
        chk("R9 sel after bubble", fwd_a_sel, 0);
        idle(); consumer(5'd9, 5'd0);
        mem_valid = 1; mem_wr = 1; mem_rd = 5'd9;
        #2 hold_bits("R2 mem match", 1);
        @(negedge clk); idle(); consumer(5'd9, 5'd0);
        ex_valid = 1; ex_wr = 1; ex_rd = 5'd3;
        #2 hold_bits("R2 no match", 0);
        @(negedge clk);
        chk("R9 sel with bypass off", fwd_a_sel, 0);
    endtask

    task automatic t_fwd();
        fwd_en = 1;
        @(negedge clk); idle(); consumer(5'd4, 5'd0);
        ex_valid = 1; ex_wr = 1; ex_rd = 5'd4;
        #2 hold_bits("R3 ex alu", 0);
        @(negedge clk);
        chk("R3 sel ex", fwd_a_sel, 2);
        idle(); consumer(5'd6, 5'd0);
        mem_valid = 1; mem_wr = 1; mem_rd = 5'd6;
        #2 hold_bits("R3 mem", 0);
        @(negedge clk);
        chk("R3 sel mem", fwd_a_sel, 1);
        idle(); consumer(5'd8, 5'd0);
        ex_valid = 1; ex_wr = 1; ex_rd = 5'd8;
        mem_valid = 1; mem_wr = 1; mem_rd = 5'd8;
        #2 hold_bits("R4 both", 0);
        @(negedge clk);
        chk("R4 sel priority", fwd_a_sel, 2);
        idle();
    endtask

    task automatic t_load();
        fwd_en = 1;
        @(negedge clk); idle(); consumer(5'd0, 5'd12);
        ex_valid = 1; ex_wr = 1; ex_load = 1; ex_rd = 5'd12;
        #2 hold_bits("R5 load use", 1);
        @(negedge clk);
        chk("R5 sel after stall", fwd_b_sel, 0);
        idle(); consumer(5'd0, 5'd12);
        mem_valid = 1; mem_wr = 1; mem_rd = 5'd12;
        #2 hold_bits("R5 follow-up", 0);
        @(negedge clk);
        chk("R5 sel mem after load", fwd_b_sel, 1);
        chk("R7 sel_a untouched", fwd_a_sel, 0);
        idle();
    endtask

    task automatic t_ignored();
        fwd_en = 0;
        @(negedge clk); idle(); consumer(5'd0, 5'd0);
        ex_valid = 1; ex_wr = 1; ex_rd = 5'd0;
        #2 hold_bits("R6 r0", 0);
        @(negedge clk); idle(); consumer(5'd5, 5'd5);
        ex_valid = 1; ex_wr = 0; ex_rd = 5'd5;
        mem_valid = 0; mem_wr = 1; mem_rd = 5'd5;
        #2 hold_bits("R6 non-writer", 0);
        @(negedge clk); idle(); consumer(5'd5, 5'd5);
        id_rs1_used = 0; id_rs2_used = 0;
        ex_valid = 1; ex_wr = 1; ex_rd = 5'd5;
        #2 hold_bits("R6 unused", 0);
        fwd_en = 1;
        #2 hold_bits("R6 unused bypass", 0);
        @(negedge clk);
        chk("R6 sel unused", fwd_a_sel, 0);
        idle(); consumer(5'd5, 5'd5); id_valid = 0;
        ex_valid = 1; ex_wr = 1; ex_rd = 5'd5; fwd_en = 0;
        #2 hold_bits("R11 empty decode", 0);
        @(negedge clk); idle(); consumer(5'd0, 5'd17);
        ex_valid = 1; ex_wr = 1; ex_rd = 5'd17; fwd_en = 1;
        #2 hold_bits("R7 second source", 0);
        @(negedge clk);
        chk("R7 sel_b", fwd_b_sel, 2);
        idle();
    endtask

    task automatic t_flush();
        fwd_en = 0;
        @(negedge clk); idle(); consumer(5'd2, 5'd0);
        ex_valid = 1; ex_wr = 1; ex_rd = 5'd2; br_taken = 1;
        #2;
        chk("R8 flush", flush_ifid, 1);
        hold_bits("R8 precedence", 0);
        @(negedge clk); idle();
        #2 chk("R8 flush drops", flush_ifid, 0);
    endtask

    task automatic t_counters();
        do_reset();
        fwd_en = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); idle(); wb_valid = 1;
        end
        for (int i = 0; i < 2; i++) begin
            @(negedge clk); idle(); consumer(5'd3, 5'd0);
            ex_valid = 1; ex_wr = 1; ex_rd = 5'd3;
        end
        @(negedge clk); idle(); br_taken = 1;
        @(negedge clk); idle();
        chk("R10 retired", retired_cnt, 5);
        chk("R10 bubbles", bubble_cnt, 3);
        @(negedge clk);
        chk("R10 idle hold", bubble_cnt, 3);
    endtask

    initial begin
        fork
            begin
                do_reset();
                t_nofwd();
                t_fwd();
                t_load();
                t_ignored();
                t_flush();
                t_counters();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule